// File: doc/BRIEF.md
# Stream Transfer Controller for a Memory Card

This block is the card-side logic for open-ended serial transfers. Commands arrive already decoded, as an index, a 32-bit argument and a one-cycle valid strobe. A stream-read command makes the block fetch bytes from an internal byte-wide memory, starting at the argument address. It shifts them out on a single data line until a stop command arrives. A stream-write command does the reverse: it gathers serial bits into bytes and stores them at consecutive addresses until a stop command arrives.

Transfers carry no length. Each error case has its own outcome:
- A start address beyond the memory is rejected.
- A wide-bus configuration makes the stream commands illegal.
- Running past the end of memory yields filler bytes and a flagged stop response.
- An underrun reported by the programming side freezes the write until stop.

Each command gets a registered response one cycle later, carrying the error flags and the state the block was in when the command arrived.

Top module: `strm_ctrl`

## Requirements
- R1: Command index 11 in Transfer state, with the 1-bit bus and an argument below DEPTH, moves the state to Sending-data. The first data bit appears on `dat_out`, with `dat_oe` high, two cycles after the response cycle.
- R2: Read data leaves MSB first, one bit per clock, from consecutive addresses that rise by one per byte, with no gap between bytes.
- R3: A stop command (index 12) in Sending-data makes `dat_oe` low and the state Transfer on the next cycle, even when it coincides with a byte boundary.
- R4: A stream command whose argument is DEPTH or larger gets a response with `rsp_addr_err` set and leaves the state at Transfer.
- R5: While `bus_wide` is high, index 11 or 20 gets a response with `rsp_illegal` set and leaves the state unchanged.
- R6: Once a read passes the last address, the block sends bytes of 0xFF. The following stop response has `rsp_addr_err` set.
- R7: Index 20 under the same conditions as R1 moves the state to Receive-data. Each group of eight `wr_bit` samples taken while `wr_bit_valid` is high forms one byte, first bit as MSB, stored at consecutive addresses. Bytes beyond the last address are dropped, and the stop response then has `rsp_addr_err` set.
- R8: An `underrun_pulse` in Receive-data causes all later bits to be ignored, including a byte that completes in the same cycle. The state stays Receive-data until stop. That stop response has `rsp_underrun` set, and the flag is cleared for the next transfer.
- R9: A stop command in Transfer gets a response with no flag set, and the state does not change.
- R10: Index 11 or 20 received outside Transfer gets a response with `rsp_illegal` set, and the state does not change.
- R11: `rsp_valid` is high exactly one cycle after each `cmd_valid`, and `rsp_state` holds the state at the command. Flags are low whenever `rsp_valid` is low.
- R12: `cur_state` reports Transfer=4, Sending-data=5 and Receive-data=6. After reset it reads 4, with `dat_oe` and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument (start address) |
| bus_wide | input | 1 | High when the bus is configured wider than one line |
| wr_bit_valid | input | 1 | Qualifies `wr_bit` |
| wr_bit | input | 1 | Serial write data |
| underrun_pulse | input | 1 | Programming side cannot keep up |
| dat_out | output | 1 | Serial read data (idle high) |
| dat_oe | output | 1 | Read data line is driven |
| rsp_valid | output | 1 | Response available |
| rsp_addr_err | output | 1 | Address range error flag |
| rsp_illegal | output | 1 | Illegal command flag |
| rsp_underrun | output | 1 | Write underrun flag |
| rsp_state | output | 4 | State when the command arrived |
| cur_state | output | 4 | Current state |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a stop command and a read byte boundary. The bench raises the stop strobe on the very negedge after the last bit of a byte, so the stop meets the next byte load on the same edge. The judgement is that the line drops on the following cycle and no bit of the next byte leaks out.

The second pair is an underrun pulse and the eighth bit of a write byte. Both are driven together. The judgement is that a later read of that address still returns the old contents.

A behavioural model compares every output on every clock.

// File: rtl/strm_pkg.sv
package strm_pkg;
  typedef enum logic [3:0] {
    ST_TRAN = 4'd4,
    ST_SEND = 4'd5,
    ST_RECV = 4'd6
  } xfer_state_e;

  localparam logic [5:0] CMD_STREAM_RD = 6'd11;
  localparam logic [5:0] CMD_STOP      = 6'd12;
  localparam logic [5:0] CMD_STREAM_WR = 6'd20;
endpackage

// File: rtl/strm_byte_ram.sv
module strm_byte_ram #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // single write port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/strm_rd_path.sv
module strm_rd_path #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW:0]       start_addr,
  input  logic              halt,
  input  logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     rd_addr,
  output logic              dat_out,
  output logic              dat_oe,
  output logic              past_end
);
  localparam int            CW       = $clog2(DATA_W);
  localparam logic [AW:0]   END_PTR  = (AW+1)'(DEPTH);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic [AW:0]       ptr;
  logic [DATA_W-1:0] shreg;
  logic [CW-1:0]     bcnt;
  logic [1:0]        prime;
  logic              active;
  logic              oe_q;
  logic              past_q;
  logic              load;

  // a new byte is taken when priming ends or the last bit has gone out
  assign load = active && ((prime == 2'd1) || (prime == 2'd0 && bcnt == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      shreg  <= '0;
      bcnt   <= '0;
      prime  <= '0;
      active <= 1'b0;
      oe_q   <= 1'b0;
      past_q <= 1'b0;
    end else if (halt) begin
      active <= 1'b0;
      oe_q   <= 1'b0;
      prime  <= '0;
      past_q <= 1'b0;
    end else if (start) begin
      ptr    <= start_addr;
      prime  <= 2'd2;
      active <= 1'b1;
      oe_q   <= 1'b0;
      past_q <= 1'b0;
    end else if (active) begin
      if (prime == 2'd2) begin
        prime <= 2'd1;
      end else if (load) begin
        prime <= 2'd0;
        oe_q  <= 1'b1;
        bcnt  <= LAST_BIT;
        if (ptr >= END_PTR) begin
          shreg  <= '1;
          past_q <= 1'b1;
        end else begin
          shreg <= rd_data;
          ptr   <= ptr + 1'b1;
        end
      end else begin
        shreg <= {shreg[DATA_W-2:0], 1'b0};
        bcnt  <= bcnt - 1'b1;
      end
    end
  end

  assign rd_addr  = ptr[AW-1:0];
  assign dat_oe   = oe_q;
  assign dat_out  = oe_q ? shreg[DATA_W-1] : 1'b1;
  assign past_end = past_q;
endmodule

// File: rtl/strm_wr_path.sv
module strm_wr_path #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW:0]       start_addr,
  input  logic              halt,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              underrun,
  output logic              we,
  output logic [AW-1:0]     waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              underrun_flag,
  output logic              past_end
);
  localparam int            CW       = $clog2(DATA_W);
  localparam logic [AW:0]   END_PTR  = (AW+1)'(DEPTH);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

  logic [AW:0]       wptr;
  logic [DATA_W-2:0] sh;
  logic [CW-1:0]     cnt;
  logic              active;
  logic              uflag_q;
  logic              past_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      sh      <= '0;
      cnt     <= '0;
      active  <= 1'b0;
      uflag_q <= 1'b0;
      past_q  <= 1'b0;
      we      <= 1'b0;
      waddr   <= '0;
      wdata   <= '0;
    end else begin
      we <= 1'b0;
      if (halt) begin
        active  <= 1'b0;
        uflag_q <= 1'b0;
        past_q  <= 1'b0;
      end else if (start) begin
        wptr    <= start_addr;
        cnt     <= '0;
        active  <= 1'b1;
        uflag_q <= 1'b0;
        past_q  <= 1'b0;
      end else if (active && underrun) begin
        // underrun beats a byte completing in the same cycle
        uflag_q <= 1'b1;
      end else if (active && !uflag_q && bit_valid) begin
        if (cnt == LAST_BIT) begin
          cnt <= '0;
          if (wptr < END_PTR) begin
            we    <= 1'b1;
            waddr <= wptr[AW-1:0];
            wdata <= {sh, bit_in};
            wptr  <= wptr + 1'b1;
          end else begin
            past_q <= 1'b1;
          end
        end else begin
          sh  <= {sh[DATA_W-3:0], bit_in};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign underrun_flag = uflag_q;
  assign past_end      = past_q;
endmodule

// File: rtl/strm_ctrl.sv
module strm_ctrl
  import strm_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [5:0]  cmd_index,
  input  logic [31:0] cmd_arg,
  input  logic        bus_wide,
  input  logic        wr_bit_valid,
  input  logic        wr_bit,
  input  logic        underrun_pulse,
  output logic        dat_out,
  output logic        dat_oe,
  output logic        rsp_valid,
  output logic        rsp_addr_err,
  output logic        rsp_illegal,
  output logic        rsp_underrun,
  output logic [3:0]  rsp_state,
  output logic [3:0]  cur_state
);
  xfer_state_e state, state_nx;
  logic start_rd, start_wr, halt_rd, halt_wr;
  logic f_addr, f_ill, f_und;
  logic rd_past, wr_past, wr_uflag;
  logic [AW-1:0]     raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  logic              we;

  always_comb begin
    state_nx = state;
    start_rd = 1'b0;
    start_wr = 1'b0;
    halt_rd  = 1'b0;
    halt_wr  = 1'b0;
    f_addr   = 1'b0;
    f_ill    = 1'b0;
    f_und    = 1'b0;
    if (cmd_valid) begin
      case (cmd_index)
        CMD_STREAM_RD, CMD_STREAM_WR: begin
          if (state != ST_TRAN || bus_wide) begin
            f_ill = 1'b1;
          end else if (cmd_arg >= 32'(DEPTH)) begin
            f_addr = 1'b1;
          end else if (cmd_index == CMD_STREAM_RD) begin
            start_rd = 1'b1;
            state_nx = ST_SEND;
          end else begin
            start_wr = 1'b1;
            state_nx = ST_RECV;
          end
        end
        CMD_STOP: begin
          if (state == ST_SEND) begin
            halt_rd  = 1'b1;
            f_addr   = rd_past;
            state_nx = ST_TRAN;
          end else if (state == ST_RECV) begin
            halt_wr  = 1'b1;
            f_addr   = wr_past;
            f_und    = wr_uflag;
            state_nx = ST_TRAN;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_TRAN;
      rsp_valid    <= 1'b0;
      rsp_addr_err <= 1'b0;
      rsp_illegal  <= 1'b0;
      rsp_underrun <= 1'b0;
      rsp_state    <= ST_TRAN;
    end else begin
      state        <= state_nx;
      rsp_valid    <= cmd_valid;
      rsp_addr_err <= f_addr;
      rsp_illegal  <= f_ill;
      rsp_underrun <= f_und;
      rsp_state    <= state;
    end
  end

  assign cur_state = state;

  strm_byte_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) ram_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  strm_rd_path #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) rd_i (
    .clk(clk), .rst(rst), .start(start_rd), .start_addr(cmd_arg[AW:0]),
    .halt(halt_rd), .rd_data(rdata), .rd_addr(raddr),
    .dat_out(dat_out), .dat_oe(dat_oe), .past_end(rd_past)
  );

  strm_wr_path #(.DEPTH(DEPTH), .DATA_W(DATA_W), .AW(AW)) wr_i (
    .clk(clk), .rst(rst), .start(start_wr), .start_addr(cmd_arg[AW:0]),
    .halt(halt_wr), .bit_valid(wr_bit_valid), .bit_in(wr_bit),
    .underrun(underrun_pulse), .we(we), .waddr(waddr), .wdata(wdata),
    .underrun_flag(wr_uflag), .past_end(wr_past)
  );
endmodule

// File: rtl/strm_ctrl_chk.sv
module strm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic [5:0] cmd_index,
  input logic       bus_wide,
  input logic       dat_oe,
  input logic       rsp_valid,
  input logic       rsp_addr_err,
  input logic       rsp_illegal,
  input logic       rsp_underrun,
  input logic [3:0] rsp_state,
  input logic [3:0] cur_state
);
  assert_state_code_R12: assert property (@(posedge clk) disable iff (rst)
    (cur_state == 4'd4 || cur_state == 4'd5 || cur_state == 4'd6));

  assert_rsp_after_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);

  assert_no_rsp_without_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid);

  assert_rsp_state_R11: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (rsp_state == $past(cur_state)));

  assert_flags_need_valid_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_addr_err || rsp_illegal || rsp_underrun) |-> rsp_valid);

  assert_oe_only_sending_R3: assert property (@(posedge clk) disable iff (rst)
    dat_oe |-> (cur_state == 4'd5));

  assert_stop_ends_read_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == 6'd12 && cur_state == 4'd5) |=> (cur_state == 4'd4 && !dat_oe));

  assert_wide_bus_illegal_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_index == 6'd11 || cmd_index == 6'd20) && bus_wide)
      |=> (rsp_illegal && $stable(cur_state)));

  assert_stop_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_index == 6'd12 && cur_state == 4'd4)
      |=> (!rsp_addr_err && !rsp_illegal && !rsp_underrun && cur_state == 4'd4));

  assert_busy_cmd_illegal_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_index == 6'd11 || cmd_index == 6'd20) && cur_state != 4'd4)
      |=> (rsp_illegal && $stable(cur_state)));

  assert_underrun_from_recv_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_underrun |-> (rsp_state == 4'd6));
endmodule

bind strm_ctrl strm_ctrl_chk chk_i (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
  .bus_wide(bus_wide), .dat_oe(dat_oe), .rsp_valid(rsp_valid),
  .rsp_addr_err(rsp_addr_err), .rsp_illegal(rsp_illegal),
  .rsp_underrun(rsp_underrun), .rsp_state(rsp_state), .cur_state(cur_state)
);

// File: tb/strm_ctrl_tb_top.sv
`timescale 1ns/1ps
module strm_ctrl_tb_top;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [5:0] cmd_index = '0;
  logic [31:0] cmd_arg = '0;
  logic bus_wide = 1'b0;
  logic wr_bit_valid = 1'b0;
  logic wr_bit = 1'b0;
  logic underrun_pulse = 1'b0;
  logic dat_out, dat_oe, rsp_valid, rsp_addr_err, rsp_illegal, rsp_underrun;
  logic [3:0] rsp_state, cur_state;

  int total = 0;
  int bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  strm_ctrl #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .bus_wide(bus_wide), .wr_bit_valid(wr_bit_valid),
    .wr_bit(wr_bit), .underrun_pulse(underrun_pulse), .dat_out(dat_out),
    .dat_oe(dat_oe), .rsp_valid(rsp_valid), .rsp_addr_err(rsp_addr_err),
    .rsp_illegal(rsp_illegal), .rsp_underrun(rsp_underrun),
    .rsp_state(rsp_state), .cur_state(cur_state)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_mem [DEPTH];
  int m_state, m_rs;
  bit m_oe, m_rv, m_ra, m_ri, m_ru;
  bit r_act, r_past, w_act, w_past, m_uf;
  int r_ptr, r_wait, r_bit, w_ptr, w_cnt;
  logic [7:0] r_byte, w_byte;
  bit s_rd, s_wr, h_rd, h_wr;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 4; m_rs = 4; m_oe = 0; m_rv = 0; m_ra = 0; m_ri = 0; m_ru = 0;
      r_act = 0; r_past = 0; w_act = 0; w_past = 0; m_uf = 0;
      r_wait = 0; w_cnt = 0;
    end else begin
      s_rd = 0; s_wr = 0; h_rd = 0; h_wr = 0;
      m_rv = cmd_valid; m_ra = 0; m_ri = 0; m_ru = 0; m_rs = m_state;
      if (cmd_valid) begin
        if (cmd_index == 6'd11 || cmd_index == 6'd20) begin
          if (m_state != 4 || bus_wide) m_ri = 1;
          else if (cmd_arg >= 32'(DEPTH)) m_ra = 1;
          else if (cmd_index == 6'd11) s_rd = 1;
          else s_wr = 1;
        end else if (cmd_index == 6'd12) begin
          if (m_state == 5) begin h_rd = 1; m_ra = r_past; end
          else if (m_state == 6) begin h_wr = 1; m_ra = w_past; m_ru = m_uf; end
        end
      end
      if (h_rd) begin
        r_act = 0; m_oe = 0; r_past = 0; m_state = 4;
      end else if (s_rd) begin
        r_ptr = int'(cmd_arg); r_wait = 2; r_act = 1; r_past = 0; m_state = 5;
      end else if (r_act) begin
        if (r_wait == 2) r_wait = 1;
        else if (r_wait == 1 || r_bit == 0) begin
          r_wait = 0; m_oe = 1; r_bit = 7;
          if (r_ptr < DEPTH) begin r_byte = 8'(m_mem[r_ptr]); r_ptr++; end
          else begin r_byte = 8'hFF; r_past = 1; end
        end else r_bit--;
      end
      if (h_wr) begin
        w_act = 0; m_uf = 0; w_past = 0; m_state = 4;
      end else if (s_wr) begin
        w_ptr = int'(cmd_arg); w_cnt = 0; w_act = 1; m_uf = 0; w_past = 0; m_state = 6;
      end else if (w_act) begin
        if (underrun_pulse) m_uf = 1;
        else if (!m_uf && wr_bit_valid) begin
          w_byte = {w_byte[6:0], wr_bit};
          w_cnt++;
          if (w_cnt == 8) begin
            w_cnt = 0;
            if (w_ptr < DEPTH) begin m_mem[w_ptr] = int'(w_byte); w_ptr++; end
            else w_past = 1;
          end
        end
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check("R12 state", 32'(cur_state), 32'(m_state));
      check("R3 line enable", 32'(dat_oe), 32'(m_oe));
      if (m_oe) check("R2 serial bit", 32'(dat_out), 32'(r_byte[r_bit]));
      check("R11 rsp valid", 32'(rsp_valid), 32'(m_rv));
      if (m_rv) check("R11 rsp state", 32'(rsp_state), 32'(m_rs));
      check("R4 addr flag", 32'(rsp_addr_err), 32'(m_ra));
      check("R5 illegal flag", 32'(rsp_illegal), 32'(m_ri));
      check("R8 underrun flag", 32'(rsp_underrun), 32'(m_ru));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit now);
    if (!now) @(negedge clk);
    cmd_valid = 1'b1; cmd_index = idx; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wr_bytes(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        @(negedge clk);
        wr_bit_valid = 1'b1; wr_bit = pat(base + k)[i];
      end
    end
    @(negedge clk);
    wr_bit_valid = 1'b0;
  endtask

  task automatic wr_one(input logic [7:0] b, input bit clash);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      wr_bit_valid = 1'b1; wr_bit = b[i];
      underrun_pulse = (clash && i == 0);
    end
    @(negedge clk);
    wr_bit_valid = 1'b0; underrun_pulse = 1'b0;
  endtask

  // call right after send_cmd has accepted a read
  task automatic rd_bytes(input int n, ref logic [7:0] got [8]);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        got[k] = {got[k][6:0], dat_out};
      end
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [7:0] got [8];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;
    // R12: reset values
    check("R12 reset state", 32'(cur_state), 32'd4);
    check("R12 reset enable", 32'(dat_oe), 32'd0);
    check("R12 reset rsp", 32'(rsp_valid), 32'd0);

    // R9: stop while idle
    send_cmd(6'd12, 0, 0);
    check("R9 stop idle flags", {rsp_addr_err, rsp_illegal, rsp_underrun}, 32'd0);
    check("R9 stop idle state", 32'(cur_state), 32'd4);

    // R7: fill memory, two extra bytes run past the end
    send_cmd(6'd20, 0, 0);
    check("R7 receive state", 32'(cur_state), 32'd6);
    wr_bytes(DEPTH + 2, 0);
    send_cmd(6'd12, 0, 0);
    check("R7 past-end write flag", 32'(rsp_addr_err), 32'd1);
    check("R11 stop rsp_state", 32'(rsp_state), 32'd6);

    // R1 R2: read three bytes from 10
    send_cmd(6'd11, 10, 0);
    check("R1 sending state", 32'(cur_state), 32'd5);
    rd_bytes(3, got);
    for (int k = 0; k < 3; k++) check("R2 read byte", 32'(got[k]), 32'(pat(10 + k)));
    // R3: stop exactly on a byte boundary
    send_cmd(6'd12, 0, 1);
    check("R3 line released", 32'(dat_oe), 32'd0);
    check("R3 back to transfer", 32'(cur_state), 32'd4);
    check("R3 no error", 32'(rsp_addr_err), 32'd0);

    // R6: run off the end
    send_cmd(6'd11, 62, 0);
    rd_bytes(4, got);
    check("R6 byte 62", 32'(got[0]), 32'(pat(62)));
    check("R6 byte 63", 32'(got[1]), 32'(pat(63)));
    check("R6 filler 1", 32'(got[2]), 32'hFF);
    check("R6 filler 2", 32'(got[3]), 32'hFF);
    send_cmd(6'd12, 0, 0);
    check("R6 stop addr flag", 32'(rsp_addr_err), 32'd1);

    // R4: out of range start
    send_cmd(6'd11, DEPTH, 0);
    check("R4 addr flag", 32'(rsp_addr_err), 32'd1);
    check("R4 stays transfer", 32'(cur_state), 32'd4);
    send_cmd(6'd20, 32'hFFFF_0000, 0);
    check("R4 write addr flag", 32'(rsp_addr_err), 32'd1);

    // R5: wide bus
    bus_wide = 1'b1;
    send_cmd(6'd11, 3, 0);
    check("R5 illegal read", 32'(rsp_illegal), 32'd1);
    check("R5 state kept", 32'(cur_state), 32'd4);
    bus_wide = 1'b0;

    // R10: stream command while busy
    send_cmd(6'd11, 0, 0);
    send_cmd(6'd20, 0, 0);
    check("R10 illegal while sending", 32'(rsp_illegal), 32'd1);
    check("R10 state kept", 32'(cur_state), 32'd5);
    send_cmd(6'd12, 0, 0);

    // R8: underrun freezes the write
    send_cmd(6'd20, 5, 0);
    wr_one(8'hA5, 0);
    @(negedge clk); underrun_pulse = 1'b1;
    @(negedge clk); underrun_pulse = 1'b0;
    wr_one(8'h00, 0);
    check("R8 still receiving", 32'(cur_state), 32'd6);
    send_cmd(6'd12, 0, 0);
    check("R8 underrun flag", 32'(rsp_underrun), 32'd1);
    check("R8 back to transfer", 32'(cur_state), 32'd4);
    send_cmd(6'd11, 5, 0);
    rd_bytes(2, got);
    check("R8 written byte", 32'(got[0]), 32'hA5);
    check("R8 ignored byte", 32'(got[1]), 32'(pat(6)));
    send_cmd(6'd12, 0, 0);
    check("R8 flag cleared", 32'(rsp_underrun), 32'd0);

    // R8: underrun on the same cycle as the eighth bit
    send_cmd(6'd20, 20, 0);
    wr_one(8'h3C, 1);
    send_cmd(6'd12, 0, 0);
    check("R8 clash flag", 32'(rsp_underrun), 32'd1);
    send_cmd(6'd11, 20, 0);
    rd_bytes(1, got);
    check("R8 clash byte kept", 32'(got[0]), 32'(pat(20)));
    send_cmd(6'd12, 0, 0);

    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule